// File: doc/BRIEF.md
# Dual Converter Simultaneous Injected Sequencer

This block coordinates two conversion engines, a master and a slave, so that both run their injected channel lists in lockstep from one shared trigger. Each engine's list holds one to four 5-bit channel numbers. The analog front end is modelled by a fixed-latency stub. The stub returns the channel number plus a per-engine offset: 256 for the master and 512 for the slave. Results land in per-engine injected result slots, and each engine raises its own end-of-sequence flag. Software clears these flags with strobes.

The master also runs a background regular channel list. An injected trigger preempts it, and once the injected group ends the regular list resumes at the channel that was cut off. An auto-delay option holds off new triggers until software has consumed the previous results. A discontinuous option makes every injected step wait for its own trigger.

Top module: `twin_inj_sequencer`

## Requirements
- R1: Injected triggers take effect only when `dualMode` equals 5'b00101. In any other mode an injected trigger changes no output.
- R2: One injected trigger starts both engines. Length fields encode the length minus one. Slot i of a channel list is bits [5i+4:5i]. Slot i of an engine's results holds channel + offset (master 256, slave 512). Each step takes CONV_CYCLES cycles, so `injBusy` stays high for (max length) × CONV_CYCLES cycles.
- R3: Each engine sets its own flag when its last channel completes. The flag holds until that engine's clear strobe arrives. An engine's interrupt is high exactly when its flag is set and its enable is high.
- R4: When the lengths differ, the shorter engine idles and no new sequence starts until the longer one has finished.
- R5: With `discEn` high, each step of the injected list waits for a separate trigger, and the flags stay low until the last step.
- R6: An injected trigger that arrives while an injected sequence is running is dropped and does not lengthen or repeat the sequence.
- R7: With `autoDly` high, an injected trigger is dropped while either end-of-sequence flag is still set.
- R8: A regular trigger converts the master's regular list (length field = length minus one) into the regular result register (read address 0) as channel + 256. An injected trigger aborts the running regular step. After the injected group, that same channel is converted again and the list continues.
- R9: With `autoDly` high, a regular trigger is dropped after a regular list completes until the master regular result is read, that is, `rdEn` high with `rdConv`=0 and `rdAddr`=0.
- R10: Read port: `rdConv` 0 selects the master and 1 the slave. `rdAddr` 0 is the regular result (always 0 for the slave). Addresses 1 to 4 are result slots 0 to 3. Addresses 5 to 7 read 0.
- R11: After reset, all flags, busy outputs, interrupts and result registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dualMode | input | 5 | Pairing mode; 5'b00101 enables simultaneous injected operation |
| injLenM | input | 2 | Master injected length minus one |
| injLenS | input | 2 | Slave injected length minus one |
| injChM | input | 20 | Master injected channel list, 4 × 5 bits |
| injChS | input | 20 | Slave injected channel list, 4 × 5 bits |
| regLen | input | 2 | Master regular length minus one |
| regCh | input | 20 | Master regular channel list, 4 × 5 bits |
| injTrig | input | 1 | Shared injected trigger |
| regTrig | input | 1 | Master regular trigger |
| discEn | input | 1 | One trigger per injected step |
| autoDly | input | 1 | Hold off triggers until results are consumed |
| eosIeM | input | 1 | Master end-of-sequence interrupt enable |
| eosIeS | input | 1 | Slave end-of-sequence interrupt enable |
| clrEosM | input | 1 | Clear master end-of-sequence flag |
| clrEosS | input | 1 | Clear slave end-of-sequence flag |
| rdEn | input | 1 | Read strobe (address 0, master = regular result consumed) |
| rdConv | input | 1 | Read engine select |
| rdAddr | input | 3 | Read address |
| rdData | output | 12 | Read data |
| eosM | output | 1 | Master end-of-sequence flag |
| eosS | output | 1 | Slave end-of-sequence flag |
| irqM | output | 1 | Master interrupt |
| irqS | output | 1 | Slave interrupt |
| injBusy | output | 1 | Injected sequence running or waiting for its next step |
| regBusy | output | 1 | Regular list active, including while preempted |

## Verification
The hardest situation to reach is an injected trigger that lands partway through a regular step. After it, the bench must still confirm that no regular channel was skipped or converted twice. To reach it, the bench counts falling edges after the regular trigger and raises the injected trigger exactly one cycle into the second regular step. It then logs every change of the regular result register and checks both the channel order and the total busy time, which includes the wasted cycle. The bench also sweeps all sixteen master/slave length pairs with distinct channel lists. For each pair it checks the busy duration and every result slot.

// File: rtl/twin_seq_pkg.sv
package twin_seq_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int ADDR_W = $clog2(SLOTS + 1);

  typedef enum logic [1:0] {S_IDLE, S_REG, S_INJ, S_WAIT} seqState_t;

  typedef struct packed {
    logic              wrM;
    logic              wrS;
    logic [SLOT_W-1:0] injIdx;
    logic              wrReg;
    logic [SLOT_W-1:0] regIdx;
  } seqStrobe_t;
endpackage

// File: rtl/twin_seq_ctrl.sv
module twin_seq_ctrl
  import twin_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 3,
  parameter int MODE_W      = 5,
  parameter logic [MODE_W-1:0] SIM_INJ_MODE = 5'b00101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] dualMode,
  input  logic [SLOT_W-1:0] injLenM,
  input  logic [SLOT_W-1:0] injLenS,
  input  logic [SLOT_W-1:0] regLen,
  input  logic              injTrig,
  input  logic              regTrig,
  input  logic              discEn,
  input  logic              autoDly,
  input  logic              clrEosM,
  input  logic              clrEosS,
  input  logic              drRead,
  output seqStrobe_t        strb,
  output logic              eosM,
  output logic              eosS,
  output logic              injBusy,
  output logic              regBusy
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CONV_CYCLES - 1);

  seqState_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] injIdx, regIdx, maxLen;
  logic              regActive, drUnread;
  logic              modeOk, convDone, injStart, regStart, lastInj, regFinish;

  always_comb begin
    modeOk    = (dualMode == SIM_INJ_MODE);
    convDone  = (cnt == '0);
    maxLen    = (injLenM > injLenS) ? injLenM : injLenS;
    lastInj   = (injIdx == maxLen);
    injStart  = injTrig && modeOk && !(autoDly && (eosM || eosS))
                && (state == S_IDLE || state == S_REG);
    regStart  = regTrig && !regActive && !(autoDly && drUnread);
    strb.injIdx = injIdx;
    strb.regIdx = regIdx;
    strb.wrM    = (state == S_INJ) && convDone && (injIdx <= injLenM);
    strb.wrS    = (state == S_INJ) && convDone && (injIdx <= injLenS);
    strb.wrReg  = (state == S_REG) && convDone && !injStart;
    regFinish   = strb.wrReg && (regIdx == regLen);
    injBusy     = (state == S_INJ) || (state == S_WAIT);
    regBusy     = regActive;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      injIdx    <= '0;
      regIdx    <= '0;
      regActive <= 1'b0;
      drUnread  <= 1'b0;
      eosM      <= 1'b0;
      eosS      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (injStart) begin
            state <= S_INJ; injIdx <= '0; cnt <= CNT_LOAD;
          end else if (regStart) begin
            state <= S_REG; cnt <= CNT_LOAD;
          end
        end
        S_REG: begin
          if (injStart) begin
            state <= S_INJ; injIdx <= '0; cnt <= CNT_LOAD;
          end else if (convDone) begin
            if (regIdx == regLen) state <= S_IDLE;
            cnt <= CNT_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_INJ: begin
          if (convDone) begin
            cnt <= CNT_LOAD;
            if (lastInj) begin
              state <= (regActive || regStart) ? S_REG : S_IDLE;
            end else begin
              injIdx <= injIdx + 1'b1;
              state  <= discEn ? S_WAIT : S_INJ;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WAIT: if (injTrig && modeOk) state <= S_INJ;
        default: state <= S_IDLE;
      endcase

      if (regStart) begin
        regActive <= 1'b1;
        regIdx    <= '0;
      end else if (regFinish) begin
        regActive <= 1'b0;
      end else if (strb.wrReg) begin
        regIdx <= regIdx + 1'b1;
      end

      if (regFinish)   drUnread <= 1'b1;
      else if (drRead) drUnread <= 1'b0;

      if (strb.wrM && injIdx == injLenM) eosM <= 1'b1;
      else if (clrEosM)                  eosM <= 1'b0;
      if (strb.wrS && injIdx == injLenS) eosS <= 1'b1;
      else if (clrEosS)                  eosS <= 1'b0;
    end
  end
endmodule

// File: rtl/twin_seq_dp.sv
module twin_seq_dp
  import twin_seq_pkg::*;
#(
  parameter int CH_W   = 5,
  parameter int DATA_W = 12,
  parameter int OFF_M  = 256,
  parameter int OFF_S  = 512
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strb,
  input  logic [SLOTS*CH_W-1:0] injChM,
  input  logic [SLOTS*CH_W-1:0] injChS,
  input  logic [SLOTS*CH_W-1:0] regCh,
  input  logic                  rdConv,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData
);
  localparam int NCONV = 2;

  logic [DATA_W-1:0] regDr;
  logic [DATA_W-1:0] slotRd [NCONV];

  always_ff @(posedge clk) begin
    if (!rstN)           regDr <= '0;
    else if (strb.wrReg) regDr <= DATA_W'(regCh[strb.regIdx*CH_W +: CH_W]) + DATA_W'(OFF_M);
  end

  for (genvar c = 0; c < NCONV; c++) begin : g_conv
    logic [SLOTS*CH_W-1:0] chList;
    logic                  wr;
    logic [DATA_W-1:0]     off;
    logic [DATA_W-1:0]     slotReg [SLOTS];

    assign chList = (c == 0) ? injChM : injChS;
    assign wr     = (c == 0) ? strb.wrM : strb.wrS;
    assign off    = (c == 0) ? DATA_W'(OFF_M) : DATA_W'(OFF_S);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < SLOTS; i++) slotReg[i] <= '0;
      end else if (wr) begin
        slotReg[strb.injIdx] <= DATA_W'(chList[strb.injIdx*CH_W +: CH_W]) + off;
      end
    end

    always_comb begin
      slotRd[c] = '0;
      for (int i = 0; i < SLOTS; i++)
        if (rdAddr == ADDR_W'(i + 1)) slotRd[c] = slotReg[i];
    end
  end

  always_comb begin
    if (rdAddr == '0) rdData = rdConv ? '0 : regDr;
    else              rdData = rdConv ? slotRd[1] : slotRd[0];
  end
endmodule

// File: rtl/twin_inj_sequencer.sv
module twin_inj_sequencer
  import twin_seq_pkg::*;
#(
  parameter int CONV_CYCLES = 3,
  parameter int CH_W        = 5,
  parameter int DATA_W      = 12,
  parameter int MODE_W      = 5,
  parameter int OFF_M       = 256,
  parameter int OFF_S       = 512
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [MODE_W-1:0]     dualMode,
  input  logic [SLOT_W-1:0]     injLenM,
  input  logic [SLOT_W-1:0]     injLenS,
  input  logic [SLOTS*CH_W-1:0] injChM,
  input  logic [SLOTS*CH_W-1:0] injChS,
  input  logic [SLOT_W-1:0]     regLen,
  input  logic [SLOTS*CH_W-1:0] regCh,
  input  logic                  injTrig,
  input  logic                  regTrig,
  input  logic                  discEn,
  input  logic                  autoDly,
  input  logic                  eosIeM,
  input  logic                  eosIeS,
  input  logic                  clrEosM,
  input  logic                  clrEosS,
  input  logic                  rdEn,
  input  logic                  rdConv,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  eosM,
  output logic                  eosS,
  output logic                  irqM,
  output logic                  irqS,
  output logic                  injBusy,
  output logic                  regBusy
);
  seqStrobe_t strb;
  logic       drRead;

  assign drRead = rdEn && !rdConv && (rdAddr == '0);
  assign irqM   = eosM && eosIeM;
  assign irqS   = eosS && eosIeS;

  twin_seq_ctrl #(.CONV_CYCLES(CONV_CYCLES), .MODE_W(MODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .dualMode(dualMode), .injLenM(injLenM), .injLenS(injLenS),
    .regLen(regLen), .injTrig(injTrig), .regTrig(regTrig), .discEn(discEn),
    .autoDly(autoDly), .clrEosM(clrEosM), .clrEosS(clrEosS), .drRead(drRead),
    .strb(strb), .eosM(eosM), .eosS(eosS), .injBusy(injBusy), .regBusy(regBusy)
  );

  twin_seq_dp #(.CH_W(CH_W), .DATA_W(DATA_W), .OFF_M(OFF_M), .OFF_S(OFF_S)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .injChM(injChM), .injChS(injChS),
    .regCh(regCh), .rdConv(rdConv), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/twin_seq_chk.sv
module twin_seq_chk #(
  parameter int MODE_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] dualMode,
  input logic              autoDly,
  input logic              eosM,
  input logic              eosS,
  input logic              injBusy,
  input logic              regBusy
);
  a_r1_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode != 5'b00101 && !injBusy) |=> !injBusy);

  a_r7_delay_gate: assert property (@(posedge clk) disable iff (!rstN)
    (autoDly && (eosM || eosS) && !injBusy) |=> !injBusy);

  a_r3_eos_m_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eosM) |-> $past(injBusy));

  a_r3_eos_s_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eosS) |-> $past(injBusy));

  a_r8_reg_held: assert property (@(posedge clk) disable iff (!rstN)
    (injBusy && regBusy) |=> regBusy);
endmodule

bind twin_inj_sequencer twin_seq_chk #(.MODE_W(MODE_W)) chk_i (
  .clk(clk), .rstN(rstN), .dualMode(dualMode), .autoDly(autoDly),
  .eosM(eosM), .eosS(eosS), .injBusy(injBusy), .regBusy(regBusy)
);

// File: tb/twin_inj_sequencer_tb_top.sv
module twin_inj_sequencer_tb_top;
  localparam int C = 3;

  logic        clk = 0, rstN = 0;
  logic [4:0]  dualMode = 5'b00101;
  logic [1:0]  injLenM = 0, injLenS = 0, regLen = 0;
  logic [19:0] injChM = 0, injChS = 0, regCh = 0;
  logic        injTrig = 0, regTrig = 0, discEn = 0, autoDly = 0;
  logic        eosIeM = 0, eosIeS = 0, clrEosM = 0, clrEosS = 0;
  logic        rdEn = 0, rdConv = 0;
  logic [2:0]  rdAddr = 0;
  logic [11:0] rdData;
  logic        eosM, eosS, irqM, irqS, injBusy, regBusy;
  int          nRun = 0, nFail = 0;

  always #10 clk = ~clk;

  twin_inj_sequencer #(.CONV_CYCLES(C)) dut_i (.*);

  task automatic check(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int chM(int i, int k); return (i * 7 + k + 1) % 32; endfunction
  function automatic int chS(int i, int k); return (i * 3 + k + 13) % 32; endfunction

  task automatic rd(input logic conv, input int addr, output int v);
    rdConv = conv; rdAddr = 3'(addr); #1; v = int'(rdData);
  endtask

  task automatic pulseInj();
    injTrig = 1; @(negedge clk); injTrig = 0;
  endtask

  task automatic clearEos();
    clrEosM = 1; clrEosS = 1; @(negedge clk); clrEosM = 0; clrEosS = 0;
  endtask

  // trigger and count negedges while busy; optional retrigger at cycle 1
  task automatic runInj(input bit retrig, output int n);
    injTrig = 1; @(negedge clk); injTrig = 0;
    n = 0;
    while (injBusy && n < 200) begin
      injTrig = retrig && (n == 1);
      @(negedge clk); n++;
    end
    injTrig = 0;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rstN = 1; @(negedge clk);

    // R11 reset state
    check("R11 eos", {eosM, eosS, irqM, irqS}, 0);
    check("R11 busy", {injBusy, regBusy}, 0);
    for (int a = 0; a < 5; a++) begin rd(0, a, v); check("R11 master data", v, 0); end

    // R1 wrong mode ignores trigger
    dualMode = 5'b00110; injChM = 20'h12345;
    pulseInj();
    repeat (3 * C) @(negedge clk);
    check("R1 busy", injBusy, 0);
    check("R1 eos", {eosM, eosS}, 0);
    rd(0, 1, v); check("R1 slot", v, 0);
    dualMode = 5'b00101;

    // R2/R4 sweep of all length pairs
    for (int k = 0; k < 16; k++) begin
      injLenM = 2'(k / 4); injLenS = 2'(k % 4);
      for (int i = 0; i < 4; i++) begin
        injChM[i*5 +: 5] = 5'(chM(i, k));
        injChS[i*5 +: 5] = 5'(chS(i, k));
      end
      runInj(0, n);
      check("R2 R4 busy duration", n, (((k / 4) > (k % 4) ? k / 4 : k % 4) + 1) * C);
      check("R3 eos both", {eosM, eosS}, 3);
      for (int i = 0; i <= k / 4; i++) begin rd(0, i + 1, v); check("R2 master slot", v, chM(i, k) + 256); end
      for (int i = 0; i <= k % 4; i++) begin rd(1, i + 1, v); check("R2 slave slot", v, chS(i, k) + 512); end
      if (k == 5) begin
        eosIeM = 1; #1;
        check("R3 irq master", irqM, 1);
        check("R3 irq slave", irqS, 0);
        eosIeM = 0;
      end
      clearEos();
      check("R3 cleared", {eosM, eosS}, 0);
    end

    // R6 retrigger during sequence dropped
    injLenM = 1; injLenS = 0;
    runInj(1, n);
    check("R6 duration", n, 2 * C);
    repeat (2 * C) @(negedge clk);
    check("R6 no restart", injBusy, 0);
    clearEos();

    // R7 auto-delay gating
    runInj(0, n);
    autoDly = 1;
    pulseInj(); @(negedge clk);
    check("R7 both set", injBusy, 0);
    clrEosM = 1; @(negedge clk); clrEosM = 0;
    pulseInj(); @(negedge clk);
    check("R7 slave set", injBusy, 0);
    clrEosS = 1; @(negedge clk); clrEosS = 0;
    runInj(0, n);
    check("R7 accepted after clears", n, 2 * C);
    clearEos(); autoDly = 0;

    // R5 discontinuous stepping
    discEn = 1; injLenM = 2; injLenS = 2;
    for (int i = 0; i < 4; i++) begin injChM[i*5 +: 5] = 5'(20 + i); injChS[i*5 +: 5] = 5'(i + 2); end
    for (int s = 0; s < 3; s++) begin
      pulseInj();
      repeat (C + 3) @(negedge clk);
      check("R5 busy while stepping", injBusy, (s < 2) ? 1 : 0);
      check("R5 eos", {eosM, eosS}, (s < 2) ? 0 : 3);
      rd(0, s + 1, v); check("R5 master step", v, 20 + s + 256);
      rd(1, s + 1, v); check("R5 slave step", v, s + 2 + 512);
    end
    discEn = 0; clearEos();

    // R8 preempt mid second regular step, resume same channel
    begin
      int seen[$]; int prev;
      regLen = 3; injLenM = 0; injLenS = 0;
      for (int i = 0; i < 4; i++) regCh[i*5 +: 5] = 5'(3 + 5 * i);
      rd(0, 0, prev);
      regTrig = 1; @(negedge clk); regTrig = 0;
      n = 0;
      while (regBusy && n < 200) begin
        injTrig = (n == C);
        rd(0, 0, v);
        if (v != prev) begin seen.push_back(v); prev = v; end
        @(negedge clk); n++;
      end
      injTrig = 0;
      rd(0, 0, v);
      if (v != prev) seen.push_back(v);
      check("R8 regular duration", n, 5 * C + 1);
      check("R8 result count", seen.size(), 4);
      for (int i = 0; i < 4 && i < seen.size(); i++) check("R8 order", seen[i], 3 + 5 * i + 256);
      check("R8 injected ran", eosM, 1);
      clearEos();
    end

    // R9 regular gate in auto-delay until result read
    autoDly = 1; regLen = 0;
    regTrig = 1; @(negedge clk); regTrig = 0; @(negedge clk);
    check("R9 unread blocks", regBusy, 0);
    rdConv = 0; rdAddr = 0; rdEn = 1; @(negedge clk); rdEn = 0;
    regTrig = 1; @(negedge clk); regTrig = 0;
    check("R9 read unblocks", regBusy, 1);
    repeat (C + 2) @(negedge clk);
    autoDly = 0;

    // R10 read map
    for (int a = 5; a < 8; a++) begin rd(0, a, v); check("R10 unused master", v, 0); rd(1, a, v); check("R10 unused slave", v, 0); end
    rd(1, 0, v); check("R10 slave regular", v, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule